// File: doc/BRIEF.md
# PCIe Root Port Reset Sequencer

This block is a controller-side state machine that brings one PCIe root port out of reset and as far as link training. A start request drives all four reset outputs low together: transaction layer, PIPE interface, internal bus interface and the endpoint's fundamental reset pin. The block then releases the three internal resets as a group, so the physical layer can come up and drive the reference clock while the endpoint stays held in reset. After a guarded wait it releases the endpoint reset. After a second settling wait it polls a link-up indication at a fixed interval until either the link comes up or a bounded timeout expires.

Every delay is given in microseconds and scaled by one cycles-per-microsecond parameter, so the same block serves any clock frequency. The wait before the endpoint reset is released defaults to 100 ms. It can be configured shorter, but it is always clamped up to the larger of the internal reset-flow minimum and the reference-clock settle time. The link-up input comes from another clock domain and passes through a synchronizer. When the timeout expires, the block freezes the current LTSSM state in an output register next to an error flag. When the link comes up, the block raises done.

Top module: `pcie_rp_rst_seq`

## Requirements
- R1: A synchronous reset, active high, takes the block to idle. In idle, all four reset outputs are low (asserted), done and error are 0, and the captured LTSSM value is 0.
- R2: In idle, or after done or error, a high start sampled on a clock edge drives all four resets low on that edge. Exactly ASSERT_US*CYC_PER_US cycles later, the transaction-layer, PIPE and bus resets all go high on the same edge, while the endpoint reset stays low.
- R3: The endpoint reset goes high exactly max(PERST_WAIT_US, MIN_RST_US, REFCLK_US)*CYC_PER_US cycles after the internal resets are released, and never earlier.
- R4: Link-up is judged no sooner than POST_PERST_US*CYC_PER_US cycles after the endpoint reset is released. Judgement k (k = 1, 2, ...) happens on the edge k*POLL_US*CYC_PER_US cycles after that wait ends.
- R5: The link-up input is judged through two register stages. The value seen at a judgement edge is the input as sampled two edges earlier.
- R6: The first judgement that sees link-up high raises done on that edge. Done then holds, with all resets released, until a new start or a reset.
- R7: If judgement number TIMEOUT_US/POLL_US still sees link-up low, error rises on that edge. On the same edge, the LTSSM input is stored in the capture output, which then holds.
- R8: Done and error are never high together. A new start clears both, and the capture output, on the start edge.
- R9: A start that arrives while a sequence is in progress has no effect on the outputs or on the timing of that sequence.
- R10: All reset outputs come from registers. The endpoint reset is never high while any internal reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a bring-up sequence |
| link_up_async | input | 1 | Link-up indication from the training logic, asynchronous |
| ltssm_state | input | LTSSM_W | Current LTSSM state code |
| tl_rst_n | output | 1 | Transaction-layer reset, active low |
| pipe_rst_n | output | 1 | PIPE interface reset, active low |
| bus_rst_n | output | 1 | Internal bus interface reset, active low |
| perst_n | output | 1 | Endpoint fundamental reset, active low |
| done | output | 1 | Link came up |
| error | output | 1 | Link-up timeout expired |
| ltssm_capture | output | LTSSM_W | LTSSM state frozen at timeout |

## Verification
The bench sets the endpoint-reset wait below the hardware minimum. A design that did not clamp it would release the endpoint reset 20 cycles early. Link-up is raised once well before the endpoint reset and once a single cycle too late for a judgement edge. A design with the wrong synchronizer depth, or one that judged link-up before the settling wait, would raise done a full poll interval away from the expected edge. Further cases are a start issued in mid-sequence, a restart from both terminal states, a reset in mid-sequence and a link-up input that toggles pseudo-randomly. A design that restarted on a late start, kept a stale flag, or stored the LTSSM value on the wrong edge shows up as a mismatch against the per-cycle model.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASSERT,
      ST_CORE,
      ST_POST,
      ST_POLL,
      ST_UP,
      ST_FAIL
   } seq_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   function automatic logic core_released(input seq_state_t s);
      return (s == ST_CORE) || (s == ST_POST) || (s == ST_POLL) ||
             (s == ST_UP) || (s == ST_FAIL);
   endfunction

   function automatic logic ep_released(input seq_state_t s);
      return (s == ST_POST) || (s == ST_POLL) || (s == ST_UP) || (s == ST_FAIL);
   endfunction

endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rrs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= 1'b0;
      else     chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[i] <= 1'b0;
         else     chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rrs_down.sv
module rrs_down #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   if (W < 1) begin : g_bad_w
      $error("rrs_down: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                    cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (zero && !load) |=> zero);  // R3

   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load && dec && !zero) |=> (cnt == $past(cnt) - 1'b1));  // R4

endmodule

// File: rtl/rrs_rst_regs.sv
module rrs_rst_regs
   import rrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  seq_state_t nxt,
   output logic       tl_rst_n,
   output logic       pipe_rst_n,
   output logic       bus_rst_n,
   output logic       perst_n,
   output logic       done,
   output logic       error
);
   always_ff @(posedge clk) begin
      if (rst) begin
         tl_rst_n   <= 1'b0;
         pipe_rst_n <= 1'b0;
         bus_rst_n  <= 1'b0;
         perst_n    <= 1'b0;
         done       <= 1'b0;
         error      <= 1'b0;
      end else begin
         tl_rst_n   <= core_released(nxt);
         pipe_rst_n <= core_released(nxt);
         bus_rst_n  <= core_released(nxt);
         perst_n    <= ep_released(nxt);
         done       <= (nxt == ST_UP);
         error      <= (nxt == ST_FAIL);
      end
   end

   AST_PERST_LAST: assert property (@(posedge clk) disable iff (rst)
      perst_n |-> (tl_rst_n && pipe_rst_n && bus_rst_n));  // R10

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(done && error));  // R8

endmodule

// File: rtl/pcie_rp_rst_seq.sv
module pcie_rp_rst_seq
   import rrs_pkg::*;
#(
   parameter int CYC_PER_US    = 125,
   parameter int ASSERT_US     = 1,
   parameter int MIN_RST_US    = 10000,
   parameter int REFCLK_US     = 30,
   parameter int PERST_WAIT_US = 100000,
   parameter int POST_PERST_US = 100000,
   parameter int POLL_US       = 20,
   parameter int TIMEOUT_US    = 50000,
   parameter int SYNC_STAGES   = 2,
   parameter int LTSSM_W       = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               link_up_async,
   input  logic [LTSSM_W-1:0] ltssm_state,
   output logic               tl_rst_n,
   output logic               pipe_rst_n,
   output logic               bus_rst_n,
   output logic               perst_n,
   output logic               done,
   output logic               error,
   output logic [LTSSM_W-1:0] ltssm_capture
);
   localparam int unsigned HOLD_US   = max3(PERST_WAIT_US, MIN_RST_US, REFCLK_US);
   localparam int unsigned A_CYC     = ASSERT_US * CYC_PER_US;
   localparam int unsigned W_CYC     = HOLD_US * CYC_PER_US;
   localparam int unsigned P_CYC     = POST_PERST_US * CYC_PER_US;
   localparam int unsigned I_CYC     = POLL_US * CYC_PER_US;
   localparam int unsigned NPOLL     = TIMEOUT_US / POLL_US;
   localparam int unsigned LONGEST   = max3(A_CYC, W_CYC, max3(P_CYC, I_CYC, 1));
   localparam int          TW        = bits_for(LONGEST);
   localparam int          PW        = bits_for(NPOLL);

   if (CYC_PER_US < 1)          begin : g_bad_cpu   $error("CYC_PER_US must be >= 1");        end
   if (ASSERT_US < 1)           begin : g_bad_asrt  $error("ASSERT_US must be >= 1");         end
   if (POST_PERST_US < 1)       begin : g_bad_post  $error("POST_PERST_US must be >= 1");     end
   if (POLL_US < 1)             begin : g_bad_poll  $error("POLL_US must be >= 1");           end
   if (TIMEOUT_US < POLL_US)    begin : g_bad_tmo   $error("TIMEOUT_US must be >= POLL_US");  end
   if (LTSSM_W < 1)             begin : g_bad_lw    $error("LTSSM_W must be >= 1");           end

   seq_state_t     state, nxt;
   logic           link_s;
   logic           t_load, t_zero;
   logic [TW-1:0]  t_val;
   logic           p_load, p_dec, p_zero;
   logic           cap_clr, cap_take;

   rrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (link_up_async),
      .q   (link_s)
   );

   rrs_down #(.W(TW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .dec      (1'b1),
      .zero     (t_zero)
   );

   rrs_down #(.W(PW)) u_polls (
      .clk      (clk),
      .rst      (rst),
      .load     (p_load),
      .load_val (PW'(NPOLL - 1)),
      .dec      (p_dec),
      .zero     (p_zero)
   );

   always_comb begin
      nxt      = state;
      t_load   = 1'b0;
      t_val    = '0;
      p_load   = 1'b0;
      p_dec    = 1'b0;
      cap_clr  = 1'b0;
      cap_take = 1'b0;
      unique case (state)
         ST_IDLE, ST_UP, ST_FAIL: begin
            if (start) begin
               nxt     = ST_ASSERT;
               t_load  = 1'b1;
               t_val   = TW'(A_CYC - 1);
               cap_clr = 1'b1;
            end
         end
         ST_ASSERT: begin
            if (t_zero) begin
               nxt    = ST_CORE;
               t_load = 1'b1;
               t_val  = TW'(W_CYC - 1);
            end
         end
         ST_CORE: begin
            if (t_zero) begin
               nxt    = ST_POST;
               t_load = 1'b1;
               t_val  = TW'(P_CYC - 1);
            end
         end
         ST_POST: begin
            if (t_zero) begin
               nxt    = ST_POLL;
               t_load = 1'b1;
               t_val  = TW'(I_CYC - 1);
               p_load = 1'b1;
            end
         end
         ST_POLL: begin
            if (t_zero) begin
               if (link_s) begin
                  nxt = ST_UP;
               end else if (p_zero) begin
                  nxt      = ST_FAIL;
                  cap_take = 1'b1;
               end else begin
                  t_load = 1'b1;
                  t_val  = TW'(I_CYC - 1);
                  p_dec  = 1'b1;
               end
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   always_ff @(posedge clk) begin
      if (rst || cap_clr) ltssm_capture <= '0;
      else if (cap_take)  ltssm_capture <= ltssm_state;
   end

   rrs_rst_regs u_regs (
      .clk        (clk),
      .rst        (rst),
      .nxt        (nxt),
      .tl_rst_n   (tl_rst_n),
      .pipe_rst_n (pipe_rst_n),
      .bus_rst_n  (bus_rst_n),
      .perst_n    (perst_n),
      .done       (done),
      .error      (error)
   );

   AST_CORE_REL_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(tl_rst_n) |-> ($past(state) == ST_ASSERT && $past(t_zero)));  // R2

   AST_PERST_REL_EDGE: assert property (@(posedge clk) disable iff (rst)
      $rose(perst_n) |-> ($past(state) == ST_CORE && $past(t_zero)));  // R3

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);  // R6

   AST_ERR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      $rose(error) |-> (ltssm_capture == $past(ltssm_state)));  // R7

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CORE && start && !t_zero) |=> (state == ST_CORE && perst_n == 1'b0));  // R9

endmodule

// File: tb/sim_pcie_rp_rst_seq.sv
module sim_pcie_rp_rst_seq;

   localparam int CPU = 1;
   localparam int A = 2;         // ASSERT_US
   localparam int W = 40;        // max(20, 40, 30)
   localparam int P = 60;        // POST_PERST_US
   localparam int I = 4;         // POLL_US
   localparam int N = 10;        // 40 / 4
   localparam int B = A + W + P; // edge where polling begins

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       link_up = 1'b0;
   logic [5:0] ltssm = 6'h00;
   logic       tl_rst_n, pipe_rst_n, bus_rst_n, perst_n, done, error;
   logic [5:0] ltssm_capture;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pcie_rp_rst_seq #(
      .CYC_PER_US (CPU), .ASSERT_US (A), .MIN_RST_US (40), .REFCLK_US (30),
      .PERST_WAIT_US (20), .POST_PERST_US (P), .POLL_US (I), .TIMEOUT_US (40),
      .SYNC_STAGES (2), .LTSSM_W (6)
   ) u0 (
      .clk (clk), .rst (rst), .start (start), .link_up_async (link_up),
      .ltssm_state (ltssm), .tl_rst_n (tl_rst_n), .pipe_rst_n (pipe_rst_n),
      .bus_rst_n (bus_rst_n), .perst_n (perst_n), .done (done), .error (error),
      .ltssm_capture (ltssm_capture)
   );

   // behavioural reference model
   bit   hist[$];
   int   cyc = -1;
   int   ts = -1;
   bit   e_done = 0, e_err = 0, e_core = 0, e_ep = 0;
   logic [5:0] e_ltssm = '0;

   always @(posedge clk) begin
      cyc = cyc + 1;
      hist.push_back(link_up);
      if (rst) begin
         ts = -1; e_done = 0; e_err = 0; e_ltssm = '0;
      end else if (start && (ts < 0 || e_done || e_err)) begin
         ts = cyc; e_done = 0; e_err = 0; e_ltssm = '0;
      end else if (ts >= 0 && !e_done && !e_err) begin
         int d;
         d = cyc - ts;
         if (d > B && (d - B) % I == 0 && cyc >= 2) begin
            if (hist[cyc-2]) e_done = 1;
            else if ((d - B) / I == N) begin
               e_err = 1; e_ltssm = ltssm;
            end
         end
      end
      if (ts < 0) begin
         e_core = 0; e_ep = 0;
      end else begin
         e_core = (cyc - ts) >= A;
         e_ep   = (cyc - ts) >= A + W;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cyc >= 0) begin
         chk(tl_rst_n == e_core,   "R2 tl_rst_n",   tl_rst_n,   e_core);
         chk(pipe_rst_n == e_core, "R2 pipe_rst_n", pipe_rst_n, e_core);
         chk(bus_rst_n == e_core,  "R2 bus_rst_n",  bus_rst_n,  e_core);
         chk(perst_n == e_ep,      "R3 perst_n",    perst_n,    e_ep);
         chk(done == e_done,       "R6 done",       done,       e_done);
         chk(error == e_err,       "R7 error",      error,      e_err);
         chk(ltssm_capture == e_ltssm, "R7 capture", ltssm_capture, e_ltssm);
         chk(!(done && error),     "R8 exclusive",  done + error, 1);
         chk(!perst_n || (tl_rst_n && pipe_rst_n && bus_rst_n), "R10 order", perst_n, 0);
      end
   end

   // pulse start; returns just after the start edge (d = 0)
   task automatic kick();
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) start = 1'b0;
   endtask

   // advance to the negedge after edge d = k, counted from d = 0
   task automatic to_d(input int now, input int k);
      repeat (k - now) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!tl_rst_n && !pipe_rst_n && !bus_rst_n && !perst_n, "R1 resets low", perst_n, 0);
      chk(!done && !error && ltssm_capture == 0, "R1 flags clear", done + error, 0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // early link-up: judged only at the first poll (R4 R5)
      link_up = 1'b1;
      kick();
      to_d(0, A - 1);
      chk(!tl_rst_n, "R2 held before release", tl_rst_n, 0);
      to_d(A - 1, A + W - 1);
      chk(!perst_n, "R3 not early despite short setting", perst_n, 0);
      to_d(A + W - 1, B + I - 1);
      chk(!done, "R4 no judgement before first poll", done, 0);
      to_d(B + I - 1, B + I);
      chk(done, "R5 done at first poll", done, 1);
      link_up = 1'b0;
      repeat (10) @(negedge clk);
      chk(done && perst_n, "R6 done holds", done, 1);

      // late by one cycle for the synchronizer (R5)
      kick();
      chk(!done && !perst_n, "R8 start clears done", done, 0);
      to_d(0, B + I - 2);
      link_up = 1'b1;
      to_d(B + I - 2, B + I);
      chk(!done, "R5 sync delay misses poll", done, 0);
      to_d(B + I, B + 2 * I);
      chk(done, "R5 caught at next poll", done, 1);
      link_up = 1'b0;

      // timeout with start ignored mid-sequence (R7 R9)
      kick();
      ltssm = 6'h2a;
      to_d(0, 60);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      to_d(61, 70);
      chk(perst_n, "R9 late start ignored", perst_n, 1);
      to_d(70, B + N * I - 1);
      chk(!error, "R7 no error before last poll", error, 0);
      to_d(B + N * I - 1, B + N * I);
      chk(error && ltssm_capture == 6'h2a, "R7 capture at timeout", ltssm_capture, 42);
      ltssm = 6'h11;
      repeat (5) @(negedge clk);
      chk(ltssm_capture == 6'h2a, "R7 capture holds", ltssm_capture, 42);

      // restart from fail, then reset mid-sequence (R8 R1)
      kick();
      chk(!error && ltssm_capture == 0, "R8 start clears error", error, 0);
      to_d(0, 50);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(!tl_rst_n && !perst_n && !done && !error, "R1 reset mid-sequence", tl_rst_n, 0);
      rst = 1'b0;
      @(negedge clk);

      // pseudo-random link-up toggling
      begin
         logic [7:0] lfsr;
         lfsr = 8'h5b;
         kick();
         for (int c = 0; c < B + N * I + 8; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            link_up = (c > B - 4) && lfsr[0] && lfsr[3] && lfsr[6];
            @(negedge clk);
         end
         link_up = 1'b0;
      end
      repeat (5) @(negedge clk);
      chk(done || error, "R6 R7 sequence finished", done + error, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule